// File: doc/BRIEF.md
# Symmetric Offset Segment Decoder

This block turns a pair of registered 16-bit two's-complement audio samples (left and right) into the switch controls of a segmented current-output DAC. Each sample is split into a coarse part and a fine part. The coarse part drives a row of 32 equal unit cells as a thermometer code. The fine part is an 11-bit code for a binary divider that splits one unit cell. A steering flag says whether the divider current is added to the lit cells or drained from them.

The mapping is symmetric about midscale. Non-negative samples light 16 or more cells and add the divider current. Negative samples light up to 16 cells and drain the divider current from them. As a result, codes -1 and 0 have the same coarse pattern and differ only in the least significant fine bit, so no coarse cell switches at the zero crossing. For every code, the weighted sum (lit cells × 2048, plus or minus the fine code) equals the sample plus 32768.

Both channels capture their sample on the same clock edge when the load strobe is high. The outputs hold between strobes.

Top module: `sod_decoder`

## Requirements
- R1: After reset, and until the first load, every coarse enable, fine code and drain flag is 0 on both channels.
- R2: Each coarse vector is a thermometer code: the lit cells always form one contiguous run starting at bit 0.
- R3: For a loaded sample with bit 15 = 0, the lit-cell count is 16 + sample[14:11], the fine code is sample[10:0], and the drain flag is 0.
- R4: For a loaded sample with bit 15 = 1, the lit-cell count is sample[14:11] + 1 if sample[10:0] is nonzero and sample[14:11] otherwise. The fine code is (2048 − sample[10:0]) mod 2048, and the drain flag is 1.
- R5: For every loaded sample, count × 2048 + fine (drain 0) or count × 2048 − fine (drain 1) equals the signed sample + 32768.
- R6: Samples 0x0000 and 0xFFFF both give 16 lit cells. Their fine codes are 0 and 1, so only the LSB fine current changes across zero.
- R7: Sample 0x8000 gives no lit cells and a fine code of 0.
- R8: Sample 0x7FFF gives 31 lit cells and a fine code of 2047. Coarse bit 31 is never set.
- R9: The outputs take the new value only on a rising clock edge with load_i high, and appear right after that edge. With load_i low, the outputs hold whatever the inputs do.
- R10: Both channels update on the same edge, each from its own sample, with no cross-coupling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture strobe for both channels |
| smp_l_i | input | 16 | Left sample, two's complement |
| smp_r_i | input | 16 | Right sample, two's complement |
| coarse_l_o | output | 32 | Left unit-cell enables, thermometer |
| fine_l_o | output | 11 | Left divider code |
| drain_l_o | output | 1 | Left divider steering: 1 subtracts, 0 adds |
| coarse_r_o | output | 32 | Right unit-cell enables, thermometer |
| fine_r_o | output | 11 | Right divider code |
| drain_r_o | output | 1 | Right divider steering: 1 subtracts, 0 adds |

## Verification
A wrong register state shows up one edge after a load, as a coarse vector with a gap, a weighted sum that misses the sample plus 32768, or a channel that takes the other channel's data. A hold fault shows up on the first idle cycle, when the outputs change while the strobe is low. The zero-crossing pair and both extremes are driven directly, because an off-by-one error in the negative-half rounding shows only there or at multiples of 2048.

// File: rtl/sod_pkg.sv
`timescale 1ns/1ps
package sod_pkg;
  localparam int DEF_DATA_W   = 16;
  localparam int DEF_COARSE_W = 5;
  localparam int NUM_CH       = 2;
endpackage

// File: rtl/sod_split.sv
`timescale 1ns/1ps
// Splits a two's-complement word into cell count, divider code and steering.
module sod_split #(
  parameter int DATA_W   = sod_pkg::DEF_DATA_W,
  parameter int COARSE_W = sod_pkg::DEF_COARSE_W,
  localparam int FINE_W  = DATA_W - COARSE_W
) (
  input  logic [DATA_W-1:0]   sample_i,
  output logic [COARSE_W-1:0] cnt_o,
  output logic [FINE_W-1:0]   fine_o,
  output logic                drain_o
);
  logic                neg;
  logic [COARSE_W-2:0] hi;
  logic [FINE_W-1:0]   lo;
  logic                lo_nz;

  assign neg   = sample_i[DATA_W-1];
  assign hi    = sample_i[DATA_W-2:FINE_W];
  assign lo    = sample_i[FINE_W-1:0];
  assign lo_nz = |lo;

  // negative half: round count up, divider drains the remainder
  always_comb begin
    if (neg) begin
      cnt_o   = {1'b0, hi} + {{(COARSE_W-1){1'b0}}, lo_nz};
      fine_o  = '0 - lo;
      drain_o = 1'b1;
    end else begin
      cnt_o   = {1'b1, hi};
      fine_o  = lo;
      drain_o = 1'b0;
    end
  end
endmodule

// File: rtl/sod_thermo.sv
`timescale 1ns/1ps
module sod_thermo #(
  parameter int CNT_W = sod_pkg::DEF_COARSE_W,
  localparam int CELLS = 2 ** CNT_W
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CELLS-1:0] vec_o
);
  for (genvar g = 0; g < CELLS; g++) begin : g_cell
    assign vec_o[g] = ({1'b0, cnt_i} > (CNT_W+1)'(g));
  end
endmodule

// File: rtl/sod_channel.sv
`timescale 1ns/1ps
module sod_channel #(
  parameter int DATA_W   = sod_pkg::DEF_DATA_W,
  parameter int COARSE_W = sod_pkg::DEF_COARSE_W,
  localparam int FINE_W  = DATA_W - COARSE_W,
  localparam int CELLS   = 2 ** COARSE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic [CELLS-1:0]  coarse_o,
  output logic [FINE_W-1:0] fine_o,
  output logic              drain_o
);
  logic [COARSE_W-1:0] cnt;
  logic [FINE_W-1:0]   fine_d;
  logic                drain_d;
  logic [CELLS-1:0]    vec_d;

  sod_split #(.DATA_W(DATA_W), .COARSE_W(COARSE_W)) u_split (
    .sample_i (sample_i),
    .cnt_o    (cnt),
    .fine_o   (fine_d),
    .drain_o  (drain_d)
  );

  sod_thermo #(.CNT_W(COARSE_W)) u_thermo (
    .cnt_i (cnt),
    .vec_o (vec_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coarse_o <= '0;
      fine_o   <= '0;
      drain_o  <= 1'b0;
    end else if (load_i) begin
      coarse_o <= vec_d;
      fine_o   <= fine_d;
      drain_o  <= drain_d;
    end
  end
endmodule

// File: rtl/sod_decoder.sv
`timescale 1ns/1ps
module sod_decoder #(
  parameter int DATA_W   = sod_pkg::DEF_DATA_W,
  parameter int COARSE_W = sod_pkg::DEF_COARSE_W,
  localparam int FINE_W  = DATA_W - COARSE_W,
  localparam int CELLS   = 2 ** COARSE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] smp_l_i,
  input  logic [DATA_W-1:0] smp_r_i,
  output logic [CELLS-1:0]  coarse_l_o,
  output logic [FINE_W-1:0] fine_l_o,
  output logic              drain_l_o,
  output logic [CELLS-1:0]  coarse_r_o,
  output logic [FINE_W-1:0] fine_r_o,
  output logic              drain_r_o
);
  localparam int NCH = sod_pkg::NUM_CH;

  logic [DATA_W-1:0] smp    [NCH];
  logic [CELLS-1:0]  coarse [NCH];
  logic [FINE_W-1:0] fine   [NCH];
  logic              drain  [NCH];

  assign smp[0] = smp_l_i;
  assign smp[1] = smp_r_i;

  // shared strobe keeps both channels on one edge
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sod_channel #(.DATA_W(DATA_W), .COARSE_W(COARSE_W)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (load_i),
      .sample_i (smp[c]),
      .coarse_o (coarse[c]),
      .fine_o   (fine[c]),
      .drain_o  (drain[c])
    );
  end

  assign coarse_l_o = coarse[0];
  assign fine_l_o   = fine[0];
  assign drain_l_o  = drain[0];
  assign coarse_r_o = coarse[1];
  assign fine_r_o   = fine[1];
  assign drain_r_o  = drain[1];
endmodule

// File: rtl/sod_decoder_chk.sv
`timescale 1ns/1ps
module sod_decoder_chk #(
  parameter int DATA_W   = sod_pkg::DEF_DATA_W,
  parameter int COARSE_W = sod_pkg::DEF_COARSE_W,
  localparam int FINE_W  = DATA_W - COARSE_W,
  localparam int CELLS   = 2 ** COARSE_W,
  localparam int MID     = CELLS / 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic [DATA_W-1:0] smp_l_i,
  input logic [DATA_W-1:0] smp_r_i,
  input logic [CELLS-1:0]  coarse_l_o,
  input logic [FINE_W-1:0] fine_l_o,
  input logic              drain_l_o,
  input logic [CELLS-1:0]  coarse_r_o,
  input logic [FINE_W-1:0] fine_r_o,
  input logic              drain_r_o
);
  p_thermo_l_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coarse_l_o & (coarse_l_o + 1'b1)) == '0);
  p_thermo_r_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coarse_r_o & (coarse_r_o + 1'b1)) == '0);

  p_top_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !coarse_l_o[CELLS-1] && !coarse_r_o[CELLS-1]);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable({coarse_l_o, fine_l_o, drain_l_o, coarse_r_o, fine_r_o, drain_r_o}));

  p_sign_l_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !smp_l_i[DATA_W-1] |=> !drain_l_o && $countones(coarse_l_o) >= MID);
  p_sign_r_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && smp_r_i[DATA_W-1] |=> drain_r_o && $countones(coarse_r_o) <= MID);

  p_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && smp_l_i == '0 |=> $countones(coarse_l_o) == MID && fine_l_o == '0);
  p_minus1_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && smp_l_i == '1 |=> $countones(coarse_l_o) == MID && fine_l_o == FINE_W'(1));

  p_min_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && smp_r_i == {1'b1, {(DATA_W-1){1'b0}}} |=> coarse_r_o == '0 && fine_r_o == '0);
endmodule

bind sod_decoder sod_decoder_chk #(.DATA_W(DATA_W), .COARSE_W(COARSE_W)) u_chk (.*);

// File: tb/tb_sod_decoder.sv
`timescale 1ns/1ps
module tb_sod_decoder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0;
  logic [15:0] smp_l_i = '0;
  logic [15:0] smp_r_i = '0;
  logic [31:0] coarse_l_o, coarse_r_o;
  logic [10:0] fine_l_o, fine_r_o;
  logic        drain_l_o, drain_r_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [15:0] held_l = '0, held_r = '0;
  bit loaded = 1'b0;

  always #2.5 clk_i = ~clk_i;

  sod_decoder dut (.*);

  function automatic int exp_cnt(logic [15:0] s);
    if (!s[15]) return 16 + int'(s[14:11]);
    return int'(s[14:11]) + ((s[10:0] != 0) ? 1 : 0);
  endfunction

  function automatic logic [10:0] exp_fine(logic [15:0] s);
    if (!s[15]) return s[10:0];
    return 11'((2048 - int'(s[10:0])) % 2048);
  endfunction

  function automatic logic [31:0] exp_vec(int k);
    logic [31:0] v = '0;
    for (int i = 0; i < k; i++) v[i] = 1'b1;
    return v;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_ch(string nm, logic [15:0] s, bit ld,
                          logic [31:0] cv, logic [10:0] fv, logic dv);
    int k, sum;
    string rq;
    if (!ld) begin
      check(cv == 32'h0 && fv == 11'h0 && !dv, "R1", {nm, " reset"}, {cv, fv, dv}, 0);
      return;
    end
    rq = s[15] ? "R4" : "R3";
    k = exp_cnt(s);
    check(cv == exp_vec(k), rq, {nm, " coarse"}, cv, exp_vec(k));
    check(fv == exp_fine(s), rq, {nm, " fine"}, fv, exp_fine(s));
    check(dv == s[15], rq, {nm, " drain"}, dv, s[15]);
    check((cv & (cv + 32'h1)) == 0, "R2", {nm, " thermometer"}, cv, exp_vec(k));
    check(!cv[31], "R8", {nm, " top cell"}, cv, 0);
    sum = $countones(cv) * 2048 + (dv ? -int'(fv) : int'(fv));
    check(sum == int'($signed(s)) + 32768, "R5", {nm, " weighted sum"}, sum, int'($signed(s)) + 32768);
  endtask

  // drive at negedge, sample at the next negedge (one edge in between)
  task automatic step(logic [15:0] l, logic [15:0] r, bit ld);
    @(negedge clk_i);
    smp_l_i = l;
    smp_r_i = r;
    load_i  = ld;
    @(negedge clk_i);
    load_i = 1'b0;
    if (ld) begin
      held_l = l;
      held_r = r;
      loaded = 1'b1;
    end
    // R9 on idle steps, R10 via independent per-channel expectations
    check_ch("L", held_l, loaded, coarse_l_o, fine_l_o, drain_l_o);
    check_ch("R", held_r, loaded, coarse_r_o, fine_r_o, drain_r_o);
  endtask

  initial begin
    void'($urandom(32'd4711));
    #12;
    check_ch("L", 16'h0, 1'b0, coarse_l_o, fine_l_o, drain_l_o); // R1
    rst_ni = 1'b1;
    step(16'h1234, 16'hCDEF, 1'b0); // R1: no load yet, still cleared
    // R6 zero crossing, R10 crossed data
    step(16'h0000, 16'hFFFF, 1'b1);
    check(coarse_l_o == coarse_r_o, "R6", "same coarse at -1/0", coarse_r_o, coarse_l_o);
    check(fine_l_o == 11'd0 && fine_r_o == 11'd1, "R6", "fine at 0/-1", {fine_l_o, fine_r_o}, 1);
    step(16'hFFFF, 16'h0000, 1'b1);
    // R7, R8 extremes
    step(16'h8000, 16'h7FFF, 1'b1);
    check(coarse_l_o == 32'h0 && fine_l_o == 11'h0, "R7", "most negative", {coarse_l_o, fine_l_o}, 0);
    check($countones(coarse_r_o) == 31 && fine_r_o == 11'd2047, "R8", "most positive",
          {coarse_r_o, fine_r_o}, {32'h7FFF_FFFF, 11'h7FF});
    step(16'h7FFF, 16'h8000, 1'b1);
    // segment boundaries
    step(16'hF800, 16'hF7FF, 1'b1);
    step(16'h07FF, 16'h0800, 1'b1);
    step(16'h8001, 16'h7800, 1'b1);
    // R9 hold with changing inputs
    step(16'h4321, 16'h9876, 1'b0);
    step(16'hAAAA, 16'h5555, 1'b0);
    for (int i = 0; i < 400; i++) begin
      step(16'($urandom), 16'($urandom), ($urandom % 4) != 0);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule